// File: doc/BRIEF.md
# Three-Operand Accumulating Execute Unit

This block sits in the execute stage of a small processor core and carries out a set of custom instructions. Each cycle it takes two source register values, a 5-bit shift amount taken from an immediate field, a two-bit operation group and a three-bit sub-operation code. From these it forms a 32-bit value for the destination register. The result is combinational. The unit's only state is a private 32-bit running register, called the accumulator here.

The accumulating operations are add, XOR, OR and AND. Each one combines three values: both sources and the current accumulator. When the step enable is high, the result goes to the destination and is also loaded into the accumulator on the clock edge. This lets software reduce a long array at two new elements per instruction. Intermediate steps may target the zero register and still advance the accumulator. The final step delivers the total to a real register.

The unit also rotates the first source left or right. Its last operation treats both sources as four bytes, multiplies matching bytes in the Rijndael field GF(2^8) and XOR-folds the four products into one byte.

Top module: `xacc_alu`

## Requirements
- R1: While the reset input is low, the accumulator is zero. It stays zero until the first enabled accumulating step after the internally synchronised release of reset, which takes two clock edges.
- R2: Operations are selected by group and code. Group 01 takes code 000 as the field dot product, 001 as add, 011 as XOR, 100 as OR and 101 as AND. Group 10 takes code 000 as rotate right and 001 as rotate left.
- R3: Add returns rs1 + rs2 + acc modulo 2^32. When enable is high, the accumulator takes that value at the clock edge.
- R4: XOR, OR and AND return the bitwise combination of rs1, rs2 and acc. When enable is high, the accumulator takes that value at the clock edge.
- R5: An AND step with either source equal to zero leaves the accumulator at zero.
- R6: The accumulator changes only on an edge where enable is high and an accumulating operation (R3, R4) is selected. The dot product, the rotates, unmapped codes and any cycle with enable low leave it unchanged.
- R7: Rotate right and rotate left move rs1 circularly by shamt bit positions. A shamt of 0 returns rs1 unchanged.
- R8: The dot product returns the XOR of the four GF(2^8) products of matching bytes of rs1 and rs2, reduced modulo x^8+x^4+x^3+x+1 (0x11B). The result sits in bits 7:0 with bits 31:8 zero.
- R9: Any group/code pair not listed in R2 returns zero.
- R10: The result of an accumulating operation uses the accumulator value held before the current clock edge, so a chain of steps returns a running total each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Step enable; allows the accumulator to load |
| grp | input | 2 | Operation group |
| sub | input | 3 | Operation code within the group |
| rs1 | input | 32 | First source operand |
| rs2 | input | 32 | Second source operand |
| shamt | input | 5 | Rotate amount |
| rd_val | output | 32 | Destination value |

## Verification
The assertions assume that the inputs are settled, with no unknown values, at every rising edge once the synchronised reset has released. They also assume that a rotate amount is meaningful only as an unsigned 5-bit count. The bench changes the inputs only just after a falling edge, always gives every input a defined value, and keeps enable low until the synchronised reset is high. This keeps the accumulator's history, as the checker sees it, in step with the bench's own running model.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

  localparam logic [1:0] GRP_ACC = 2'b01;
  localparam logic [1:0] GRP_ROT = 2'b10;

  localparam logic [2:0] SUB_GFDOT = 3'b000;
  localparam logic [2:0] SUB_ADD   = 3'b001;
  localparam logic [2:0] SUB_XOR   = 3'b011;
  localparam logic [2:0] SUB_OR    = 3'b100;
  localparam logic [2:0] SUB_AND   = 3'b101;
  localparam logic [2:0] SUB_ROR   = 3'b000;
  localparam logic [2:0] SUB_ROL   = 3'b001;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_GFDOT,
    OP_ADD,
    OP_XOR,
    OP_OR,
    OP_AND,
    OP_ROR,
    OP_ROL
  } xop_e;

  function automatic xop_e decode_op(input logic [1:0] g, input logic [2:0] s);
    xop_e op;
    op = OP_NONE;
    if (g == GRP_ACC) begin
      case (s)
        SUB_GFDOT: op = OP_GFDOT;
        SUB_ADD:   op = OP_ADD;
        SUB_XOR:   op = OP_XOR;
        SUB_OR:    op = OP_OR;
        SUB_AND:   op = OP_AND;
        default:   op = OP_NONE;
      endcase
    end else if (g == GRP_ROT) begin
      case (s)
        SUB_ROR: op = OP_ROR;
        SUB_ROL: op = OP_ROL;
        default: op = OP_NONE;
      endcase
    end
    return op;
  endfunction

  function automatic logic is_accum(input xop_e op);
    return (op == OP_ADD) || (op == OP_XOR) || (op == OP_OR) || (op == OP_AND);
  endfunction

  // Shift-and-add multiply in GF(2^8); red_lo holds the low eight bits of the modulus
  function automatic logic [7:0] gf8_mul(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] red_lo);
    logic [7:0] prod;
    logic [7:0] term;
    prod = '0;
    term = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) prod = prod ^ term;
      term = term[7] ? ({term[6:0], 1'b0} ^ red_lo) : {term[6:0], 1'b0};
    end
    return prod;
  endfunction

endpackage

// File: rtl/xalu_rst_sync.sv
module xalu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xalu_gf_dot.sv
module xalu_gf_dot #(
  parameter int         DATA_W = 32,
  parameter logic [7:0] RED_LO = 8'h1B
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [7:0]        dot
);
  import xalu_pkg::*;

  localparam int NBYTES = DATA_W / 8;

  logic [7:0] prod [NBYTES];

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    always_comb begin
      prod[k] = gf8_mul(a[8*k +: 8], b[8*k +: 8], RED_LO);
    end
  end

  always_comb begin
    dot = '0;
    for (int k = 0; k < NBYTES; k++) dot = dot ^ prod[k];
  end
endmodule

// File: rtl/xalu_rotator.sv
module xalu_rotator #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  logic              to_left,
  output logic [DATA_W-1:0] dout
);
  logic [SH_W-1:0]   r_amt;
  logic [DATA_W-1:0] stage [SH_W+1];

  // A left rotate by n equals a right rotate by (DATA_W - n) mod DATA_W
  always_comb begin
    r_amt = to_left ? (~amt + 1'b1) : amt;
  end

  assign stage[0] = din;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int D = 1 << s;
    always_comb begin
      stage[s+1] = r_amt[s] ? {stage[s][D-1:0], stage[s][DATA_W-1:D]} : stage[s];
    end
  end

  assign dout = stage[SH_W];
endmodule

// File: rtl/xalu_acc_reg.sv
module xalu_acc_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] acc_q
);
  logic [DATA_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (load) acc_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/xacc_alu.sv
module xacc_alu #(
  parameter int         DATA_W = 32,
  parameter int         SH_W   = $clog2(DATA_W),
  parameter logic [7:0] RED_LO = 8'h1B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        grp,
  input  logic [2:0]        sub,
  input  logic [DATA_W-1:0] rs1,
  input  logic [DATA_W-1:0] rs2,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] rd_val
);
  import xalu_pkg::*;

  xop_e              op;
  logic              rst_s_n;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] tri_res;
  logic [DATA_W-1:0] rot_res;
  logic [7:0]        dot_res;
  logic              acc_load;

  xalu_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_s_n)
  );

  xalu_gf_dot #(.DATA_W(DATA_W), .RED_LO(RED_LO)) u_gf (
    .a  (rs1),
    .b  (rs2),
    .dot(dot_res)
  );

  xalu_rotator #(.DATA_W(DATA_W), .SH_W(SH_W)) u_rot (
    .din    (rs1),
    .amt    (shamt),
    .to_left(op == OP_ROL),
    .dout   (rot_res)
  );

  always_comb begin
    op = decode_op(grp, sub);
  end

  // Three-input combine using the accumulator value held before the edge
  always_comb begin
    unique case (op)
      OP_ADD:  tri_res = rs1 + rs2 + acc_q;
      OP_XOR:  tri_res = rs1 ^ rs2 ^ acc_q;
      OP_OR:   tri_res = rs1 | rs2 | acc_q;
      OP_AND:  tri_res = rs1 & rs2 & acc_q;
      default: tri_res = '0;
    endcase
  end

  always_comb begin
    case (op)
      OP_ADD, OP_XOR, OP_OR, OP_AND: rd_val = tri_res;
      OP_ROR, OP_ROL:                rd_val = rot_res;
      OP_GFDOT:                      rd_val = {{(DATA_W-8){1'b0}}, dot_res};
      default:                       rd_val = '0;
    endcase
  end

  always_comb begin
    acc_load = en && is_accum(op);
  end

  xalu_acc_reg #(.DATA_W(DATA_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load    (acc_load),
    .load_val(tri_res),
    .acc_q   (acc_q)
  );
endmodule

// File: rtl/xacc_alu_chk.sv
module xacc_alu_chk #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              en,
  input logic [1:0]        grp,
  input logic [2:0]        sub,
  input logic [DATA_W-1:0] rs1,
  input logic [DATA_W-1:0] rs2,
  input logic [SH_W-1:0]   shamt,
  input logic [DATA_W-1:0] rd_val,
  input logic [DATA_W-1:0] acc_q
);
  logic acc_kind;
  logic mapped;
  logic is_ror;
  logic is_rol;
  logic is_dot;

  always_comb begin
    acc_kind = (grp == 2'b01) && (sub == 3'b001 || sub == 3'b011 ||
                                  sub == 3'b100 || sub == 3'b101);
    is_dot   = (grp == 2'b01) && (sub == 3'b000);
    is_ror   = (grp == 2'b10) && (sub == 3'b000);
    is_rol   = (grp == 2'b10) && (sub == 3'b001);
    mapped   = acc_kind || is_dot || is_ror || is_rol;
  end

  // R3 R4: an enabled accumulating step leaves its result in the accumulator
  assert_acc_follows_R3 : assert property (@(posedge clk) disable iff (!rst_s_n)
    (en && acc_kind) |=> (acc_q == $past(rd_val)));

  // R6: no other cycle moves the accumulator
  assert_acc_held_R6 : assert property (@(posedge clk) disable iff (!rst_s_n)
    !(en && acc_kind) |=> $stable(acc_q));

  // R5: an enabled AND with a zero source empties the accumulator
  assert_and_clear_R5 : assert property (@(posedge clk) disable iff (!rst_s_n)
    (en && grp == 2'b01 && sub == 3'b101 && (rs1 == '0 || rs2 == '0)) |=> (acc_q == '0));

  // R7: undoing a right rotate restores the source
  assert_ror_inverse_R7 : assert property (@(posedge clk) disable iff (!rst_s_n)
    is_ror |-> (((rd_val << shamt) | (rd_val >> (DATA_W - int'(shamt)))) == rs1));

  // R7: undoing a left rotate restores the source
  assert_rol_inverse_R7 : assert property (@(posedge clk) disable iff (!rst_s_n)
    is_rol |-> (((rd_val >> shamt) | (rd_val << (DATA_W - int'(shamt)))) == rs1));

  // R8: the field result occupies only the low byte
  assert_dot_width_R8 : assert property (@(posedge clk) disable iff (!rst_s_n)
    is_dot |-> (rd_val[DATA_W-1:8] == '0));

  // R9: unmapped selections return zero
  assert_unmapped_zero_R9 : assert property (@(posedge clk) disable iff (!rst_s_n)
    !mapped |-> (rd_val == '0));
endmodule

bind xacc_alu xacc_alu_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) u_chk (
  .clk    (clk),
  .rst_s_n(rst_s_n),
  .en     (en),
  .grp    (grp),
  .sub    (sub),
  .rs1    (rs1),
  .rs2    (rs2),
  .shamt  (shamt),
  .rd_val (rd_val),
  .acc_q  (acc_q)
);

// File: tb/tb_xacc_alu.sv
module tb_xacc_alu;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [1:0]  grp;
  logic [2:0]  sub;
  logic [31:0] rs1;
  logic [31:0] rs2;
  logic [4:0]  shamt;
  logic [31:0] rd_val;

  int          n_checks;
  int          n_fail;
  logic [31:0] macc;
  bit          finished;

  xacc_alu dut (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .grp   (grp),
    .sub   (sub),
    .rs1   (rs1),
    .rs2   (rs2),
    .shamt (shamt),
    .rd_val(rd_val)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Carry-less product followed by polynomial reduction by 0x11B
  function automatic logic [7:0] ref_gf(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] c;
    c = '0;
    for (int i = 0; i < 8; i++) if (b[i]) c = c ^ (15'(a) << i);
    for (int k = 14; k >= 8; k--) if (c[k]) c = c ^ (15'h11B << (k - 8));
    return c[7:0];
  endfunction

  function automatic logic [31:0] ref_rd(input logic [1:0] g, input logic [2:0] s,
                                         input logic [31:0] a, input logic [31:0] b,
                                         input logic [4:0] sh, input logic [31:0] acc);
    logic [63:0] dbl;
    logic [7:0]  d;
    dbl = {a, a};
    if (g == 2'b01) begin
      case (s)
        3'b000: begin
          d = ref_gf(a[7:0], b[7:0]) ^ ref_gf(a[15:8], b[15:8]) ^
              ref_gf(a[23:16], b[23:16]) ^ ref_gf(a[31:24], b[31:24]);
          return {24'h0, d};
        end
        3'b001: return a + b + acc;
        3'b011: return a ^ b ^ acc;
        3'b100: return a | b | acc;
        3'b101: return a & b & acc;
        default: return 32'h0;
      endcase
    end else if (g == 2'b10) begin
      if (s == 3'b000) begin
        dbl = dbl >> sh;
        return dbl[31:0];
      end
      if (s == 3'b001) begin
        dbl = dbl << sh;
        return dbl[63:32];
      end
      return 32'h0;
    end
    return 32'h0;
  endfunction

  function automatic bit ref_accum(input logic [1:0] g, input logic [2:0] s);
    return (g == 2'b01) && (s == 3'b001 || s == 3'b011 || s == 3'b100 || s == 3'b101);
  endfunction

  task automatic step(input logic [1:0] g, input logic [2:0] s, input logic [31:0] a,
                      input logic [31:0] b, input logic [4:0] sh, input logic e,
                      input string req);
    logic [31:0] exp_v;
    @(negedge clk);
    grp = g; sub = s; rs1 = a; rs2 = b; shamt = sh; en = e;
    #1;
    exp_v = ref_rd(g, s, a, b, sh, macc);
    n_checks++;
    if (rd_val !== exp_v) begin
      n_fail++;
      $display("FAIL %s grp=%b sub=%b rs1=%h rs2=%h sh=%0d actual=%h expected=%h",
               req, g, s, a, b, sh, rd_val, exp_v);
    end
    @(posedge clk);
    if (e && rst_n && ref_accum(g, s)) macc = exp_v;
  endtask

  // Read the accumulator through an add of zeros with enable low
  task automatic peek_acc(input string req);
    step(2'b01, 3'b001, 32'h0, 32'h0, 5'd0, 1'b0, req);
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] total;
    logic [31:0] pat [8];
    n_checks = 0; n_fail = 0; macc = '0; finished = 0;
    rst_n = 1'b0; en = 1'b0; grp = '0; sub = '0; rs1 = '0; rs2 = '0; shamt = '0;

    // R1: accumulator reads zero during reset
    repeat (2) @(posedge clk);
    peek_acc("R1");
    step(2'b01, 3'b001, 32'd5, 32'd7, 5'd0, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    peek_acc("R1");

    // R5: clear, R3 R10: chained reduction of 1000 values in 500 steps
    step(2'b01, 3'b101, 32'h0, 32'hFFFF_FFFF, 5'd0, 1'b1, "R5");
    peek_acc("R5");
    total = '0;
    for (int i = 0; i < 500; i++) begin
      logic [31:0] va, vb;
      va = 32'(2*i) * 32'd7919 + 32'd3;
      vb = 32'(2*i+1) * 32'd7919 + 32'd3;
      total = total + va + vb;
      step(2'b01, 3'b001, va, vb, 5'd0, 1'b1, "R10");
    end
    n_checks++;
    if (macc !== total) begin
      n_fail++;
      $display("FAIL R3 reduction actual=%h expected=%h", macc, total);
    end
    peek_acc("R3");

    // R6: enable low changes nothing
    for (int i = 0; i < 50; i++)
      step(2'b01, 3'(1 + 2*(i % 3)), $urandom, $urandom, 5'd0, 1'b0, "R6");
    peek_acc("R6");

    // R4: three-way logic operations
    for (int i = 0; i < 300; i++) begin
      logic [2:0] s;
      s = (i % 3 == 0) ? 3'b011 : ((i % 3 == 1) ? 3'b100 : 3'b101);
      step(2'b01, s, $urandom, $urandom, 5'd0, 1'b1, "R4");
      if (i % 10 == 9) step(2'b01, 3'b100, 32'h0, 32'h0, 5'd0, 1'b1, "R4");
    end
    for (int i = 0; i < 200; i++)
      step(2'b01, 3'b001, $urandom, $urandom, 5'd0, 1'b1, "R3");

    // R5: zero in either operand
    step(2'b01, 3'b100, 32'hDEAD_BEEF, 32'h1234_5678, 5'd0, 1'b1, "R4");
    step(2'b01, 3'b101, 32'hFFFF_FFFF, 32'h0, 5'd0, 1'b1, "R5");
    peek_acc("R5");
    step(2'b01, 3'b011, 32'hA5A5_0F0F, 32'h0, 5'd0, 1'b1, "R4");
    step(2'b01, 3'b101, 32'h0, 32'hFFFF_FFFF, 5'd0, 1'b1, "R5");
    peek_acc("R5");
    step(2'b01, 3'b011, 32'h0BAD_F00D, 32'h1, 5'd0, 1'b1, "R4");

    // R7: rotates over every amount; R6: accumulator untouched
    pat[0] = 32'h0000_0001; pat[1] = 32'h8000_0000; pat[2] = 32'hDEAD_BEEF;
    pat[3] = 32'hFFFF_FFFE; pat[4] = 32'h1234_5678; pat[5] = 32'h0;
    pat[6] = 32'hF0F0_0F0F; pat[7] = 32'h7FFF_FFFF;
    for (int p = 0; p < 8; p++) begin
      for (int sh = 0; sh < 32; sh++) begin
        step(2'b10, 3'b000, pat[p], $urandom, 5'(sh), 1'b1, "R7");
        step(2'b10, 3'b001, pat[p], $urandom, 5'(sh), 1'b1, "R7");
      end
      peek_acc("R6");
    end

    // R8: every byte pair across all four lanes
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        logic [7:0] x, y;
        x = 8'(a); y = 8'(b);
        step(2'b01, 3'b000, {x ^ 8'h5A, ~x, x + 8'd1, x},
             {y, y ^ 8'hC3, ~y, y}, 5'(a), 1'b1, "R8");
      end
    end
    peek_acc("R6");

    // R2 R9: every group/code pair with enable high
    for (int g = 0; g < 4; g++) begin
      for (int s = 0; s < 8; s++) begin
        step(2'(g), 3'(s), $urandom, $urandom, 5'($urandom), 1'b1, "R2");
        peek_acc("R9");
      end
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule